// File: doc/BRIEF.md
# Boot-Area Command Sequencer

This block interprets the 16-bit values that a host writes into the boot-buffer window of a paged flash device, where a small command language applies instead of plain memory writes. It recognises three command values: a warm reset, a read-identification request, and a two-write page-load handshake. It holds the one-bit "second cycle armed" state and the block and page start-address registers. From those registers it forms the sector number to fetch.

A page load sends one request with a sector number to the array port and holds it until the array acknowledges. The page register then moves forward by one page (four sectors), wrapping within 8 bits. Read identification writes three words into the boot buffer through a word-write port on three consecutive cycles. While a load or an identification sequence is in progress the block reports busy and drops any boot-window write. A separate register-write port loads the block address, the page address and the buffer-start field.

Top module: `boot_cmd_seq`

## Requirements
- R1: After reset the block and page registers read 0, the buffer address reads 0, the sector count reads 1, the block is not armed, and `arr_req`, `bb_we`, `busy` and `unk_cmd` are low.
- R2: A boot-window write of 0x00E0 while not armed sets `armed` after the next clock edge. The next accepted boot-window write clears `armed`, whatever its value.
- R3: An accepted write of 0x0000 while armed raises `arr_req` after the next clock edge. `arr_sector` then equals `page[1:0] + ((page[7:2] + (B << 6)) << 2)`, where B is the effective block value of R6 (default of 2 KB pages).
- R4: While `arr_req` is high and `arr_ack` is low, `arr_req` stays high and `arr_sector` holds its value. One cycle with `arr_ack` high clears `arr_req`.
- R5: On the cycle that completes a load, the page register becomes `(page + 4) mod 256`, and its bits 15:8 are cleared.
- R6: The effective block value B is `blk[11:0]`, ORed with the parameter `DENS_MASK` when `blk[15]` is 1. Block bits 14:12 do not enter the sector number.
- R7: An accepted write other than 0x0000 while armed clears `armed`. It starts no load and does not raise `unk_cmd`.
- R8: A write of 0x0090 while not armed produces three boot-buffer word writes on consecutive cycles: word 0 = manufacturer ID, word 1 = device ID, word 2 = `{8'h00, wp_status}`.
- R9: A write of 0x00F0 while not armed clears the block and page registers and the buffer address, and sets the sector count to 1.
- R10: Any other value written while not armed raises `unk_cmd` for exactly one cycle and changes no register.
- R11: `busy` is high while a load is waiting or an identification sequence is running, and boot-window writes made during that time are dropped.
- R12: A register write with `reg_sel`=2 sets the buffer address to `reg_wdata[11:8]`. It sets the sector count to `reg_wdata[1:0]`, or to 4 when that field is 0. `reg_sel`=0 writes the block register and `reg_sel`=1 writes the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Boot-window write strobe |
| wr_data | input | 16 | Boot-window write value |
| reg_we | input | 1 | Start-register write strobe |
| reg_sel | input | 2 | 0 block, 1 page, 2 buffer-start, 3 none |
| reg_wdata | input | 16 | Start-register write value |
| wp_status | input | 8 | Write-protect status byte for identification |
| arr_ack | input | 1 | Array port completion |
| arr_req | output | 1 | Array page-load request |
| arr_sector | output | 22+PG_SHIFT | Sector number of the requested page |
| bb_we | output | 1 | Boot-buffer word write strobe |
| bb_addr | output | 2 | Boot-buffer word index |
| bb_wdata | output | 16 | Boot-buffer word value |
| busy | output | 1 | Load or identification in progress |
| armed | output | 1 | Second load cycle armed |
| unk_cmd | output | 1 | One-cycle flag for an unknown command |
| blk_q | output | 16 | Block start address |
| page_q | output | 16 | Page start address |
| bufaddr_q | output | 4 | Buffer start address |
| count_q | output | PG_SHIFT+1 | Sector count |

## Verification
Some properties are checked on every cycle. A waiting request holds its value and a stable sector until acknowledged. The array request and the boot-buffer writes are never active together. Boot-buffer word indices advance in order. A write offered while busy leaves the armed state unchanged. Arming and load start follow the accepted write by one edge. Other results can only be shown by the bench scenarios, which compare against independently computed values: the exact sector arithmetic with the density bit, the page wrap, the identification word contents, the warm-reset values, the one-cycle unknown-command flag, and the loss of writes made while busy.

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq #(
  parameter int          PG_SHIFT  = 2,
  parameter logic [15:0] DENS_MASK = 16'h0200,
  parameter logic [7:0]  MFR_ID    = 8'hEC,
  parameter logic [7:0]  DEV_ID    = 8'h36,
  localparam int         SW        = 22 + PG_SHIFT,
  localparam int         CW        = PG_SHIFT + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [15:0]   reg_wdata,
  input  logic [7:0]    wp_status,
  input  logic          arr_ack,
  output logic          arr_req,
  output logic [SW-1:0] arr_sector,
  output logic          bb_we,
  output logic [1:0]    bb_addr,
  output logic [15:0]   bb_wdata,
  output logic          busy,
  output logic          armed,
  output logic          unk_cmd,
  output logic [15:0]   blk_q,
  output logic [15:0]   page_q,
  output logic [3:0]    bufaddr_q,
  output logic [CW-1:0] count_q
);

  localparam logic [15:0]   CMD_RST  = 16'h00F0;
  localparam logic [15:0]   CMD_LOAD = 16'h00E0;
  localparam logic [15:0]   CMD_ID   = 16'h0090;
  localparam logic [CW-1:0] SPP      = CW'(1 << PG_SHIFT);

  logic [1:0]    id_ph;
  logic [15:0]   blk_eff;
  logic [SW-1:0] sec_next;
  logic          take, done;
  logic [CW-1:0] cnt_field;

  assign blk_eff   = {4'h0, blk_q[11:0]} | (blk_q[15] ? DENS_MASK : 16'h0000);
  assign sec_next  = SW'(page_q[1:0]) + (SW'({blk_eff, page_q[7:2]}) << PG_SHIFT);
  assign busy      = arr_req | (id_ph != 2'd0);
  assign take      = wr_en & ~busy;
  assign done      = arr_req & arr_ack;
  assign cnt_field = CW'(reg_wdata[PG_SHIFT-1:0]);

  assign bb_we    = (id_ph != 2'd0);
  assign bb_addr  = id_ph - 2'd1;
  assign bb_wdata = (id_ph == 2'd1) ? {8'h00, MFR_ID} :
                    (id_ph == 2'd2) ? {8'h00, DEV_ID} :
                    (id_ph == 2'd3) ? {8'h00, wp_status} : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_req    <= 1'b0;
      arr_sector <= '0;
      armed      <= 1'b0;
      unk_cmd    <= 1'b0;
      id_ph      <= 2'd0;
      blk_q      <= 16'h0000;
      page_q     <= 16'h0000;
      bufaddr_q  <= 4'h0;
      count_q    <= CW'(1);
    end else begin
      unk_cmd <= 1'b0;
      if (id_ph != 2'd0) id_ph <= id_ph + 2'd1;
      if (reg_we) begin
        case (reg_sel)
          2'd0: blk_q <= reg_wdata;
          2'd1: page_q <= reg_wdata;
          2'd2: begin
            bufaddr_q <= reg_wdata[11:8];
            count_q   <= (cnt_field == '0) ? SPP : cnt_field;
          end
          default: ;
        endcase
      end
      if (done) begin
        arr_req <= 1'b0;
        page_q  <= {8'h00, page_q[7:0] + 8'd4};
      end
      if (take) begin
        if (armed) begin
          armed <= 1'b0;
          if (wr_data == 16'h0000) begin
            arr_req    <= 1'b1;
            arr_sector <= sec_next;
          end
        end else begin
          case (wr_data)
            CMD_RST: begin
              blk_q     <= 16'h0000;
              page_q    <= 16'h0000;
              bufaddr_q <= 4'h0;
              count_q   <= CW'(1);
            end
            CMD_LOAD: armed <= 1'b1;
            CMD_ID:   id_ph <= 2'd1;
            default:  unk_cmd <= 1'b1;
          endcase
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_ack |=> arr_req && $stable(arr_sector)); // R4
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_ack |=> !arr_req); // R4
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && armed && wr_data == 16'h0000 |=> arr_req && !armed); // R3
  AST_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && !armed && wr_data == CMD_LOAD |=> armed); // R2
  AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && armed |=> !armed); // R7
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> $stable(armed)); // R11
  AST_ID_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    bb_we && bb_addr != 2'd2 |=> bb_we && bb_addr == $past(bb_addr) + 2'd1); // R8
  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_req, bb_we})); // R11

endmodule

// File: tb/boot_cmd_seq_tb.sv
`timescale 1ns/1ps
module boot_cmd_seq_tb;
  localparam logic [15:0] DMASK = 16'h0200;
  localparam logic [7:0]  MFR = 8'hEC, DEV = 8'h36;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, reg_we = 0, arr_ack = 0;
  logic [15:0] wr_data = 0, reg_wdata = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] wp_status = 8'h02;
  logic arr_req, bb_we, busy, armed, unk_cmd;
  logic [23:0] arr_sector;
  logic [1:0] bb_addr;
  logic [15:0] bb_wdata, blk_q, page_q;
  logic [3:0] bufaddr_q;
  logic [2:0] count_q;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_blk = 0, m_page = 0;
  logic [3:0] m_buf = 0;
  logic [2:0] m_cnt = 1;
  bit m_arm = 0;

  boot_cmd_seq u_dut (.*);

  always #2 clk = ~clk;

  function automatic logic [23:0] exp_sec(logic [15:0] b, logic [15:0] p);
    int bt;
    bt = (b & 16'h0FFF) | (b[15] ? DMASK : 16'h0);
    return 24'((p & 3) + ((((p >> 2) & 63) + (bt << 6)) << 2));
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic chk_regs(string r);
    chk(blk_q == m_blk, r, blk_q, m_blk);
    chk(page_q == m_page, r, page_q, m_page);
    chk(bufaddr_q == m_buf, r, bufaddr_q, m_buf);
    chk(count_q == m_cnt, r, count_q, m_cnt);
    chk(armed == m_arm, r, armed, m_arm);
  endtask

  task automatic bw(logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rw(logic [1:0] s, logic [15:0] v);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = v;
    @(negedge clk); reg_we = 0;
    case (s)
      2'd0: m_blk = v;
      2'd1: m_page = v;
      2'd2: begin m_buf = v[11:8]; m_cnt = (v[1:0] == 0) ? 3'd4 : {1'b0, v[1:0]}; end
      default: ;
    endcase
    chk_regs("R12");
  endtask

  task automatic do_load(int dly, bit poke);
    logic [23:0] es;
    es = exp_sec(m_blk, m_page);
    bw(16'h00E0); m_arm = 1;
    chk(armed == 1, "R2", armed, 1);
    bw(16'h0000); m_arm = 0;
    chk(arr_req == 1, "R3", arr_req, 1);
    chk(arr_sector == es, "R3 R6", arr_sector, es);
    chk(busy == 1 && armed == 0, "R11", {busy, armed}, 2'b10);
    if (poke) begin
      bw(16'h00F0);
      chk(arr_req == 1 && page_q == m_page, "R11", page_q, m_page);
    end
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(arr_req == 1 && arr_sector == es, "R4", arr_sector, es);
    end
    arr_ack = 1;
    @(negedge clk); arr_ack = 0;
    m_page = {8'h00, m_page[7:0] + 8'd4};
    chk(arr_req == 0 && busy == 0, "R4", arr_req, 0);
    chk_regs("R5");
  endtask

  task automatic do_id(bit poke);
    bw(16'h0090);
    chk(bb_we && bb_addr == 0 && bb_wdata == {8'h0, MFR}, "R8", bb_wdata, MFR);
    if (poke) begin
      bw(16'h00E0);
      chk(bb_we && bb_addr == 2 && bb_wdata == {8'h0, wp_status}, "R8", bb_wdata, wp_status);
      chk(armed == 0, "R11", armed, 0);
    end else begin
      @(negedge clk);
      chk(bb_we && bb_addr == 1 && bb_wdata == {8'h0, DEV}, "R8", bb_wdata, DEV);
      @(negedge clk);
      chk(bb_we && bb_addr == 2 && bb_wdata == {8'h0, wp_status}, "R8", bb_wdata, wp_status);
    end
    @(negedge clk);
    chk(bb_we == 0 && busy == 0, "R8", bb_we, 0);
  endtask

  task automatic do_unk(logic [15:0] v);
    bw(v);
    chk(unk_cmd == 1, "R10", unk_cmd, 1);
    chk_regs("R10");
    @(negedge clk);
    chk(unk_cmd == 0, "R10", unk_cmd, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(arr_req == 0 && bb_we == 0 && busy == 0 && unk_cmd == 0, "R1", {arr_req, bb_we, busy, unk_cmd}, 0);
    chk_regs("R1");
    rst_n = 1;
    @(negedge clk);

    rw(2'd0, 16'h0005); rw(2'd1, 16'h0013);
    do_load(0, 0);
    rw(2'd0, 16'h8007); rw(2'd1, 16'h01FE);
    do_load(3, 1);
    chk(page_q == 16'h0002, "R5", page_q, 16'h0002);
    rw(2'd0, 16'h7ABC);
    do_load(1, 0);
    bw(16'h00E0); m_arm = 1;
    bw(16'h1234); m_arm = 0;
    chk(arr_req == 0 && unk_cmd == 0, "R7", {arr_req, unk_cmd}, 0);
    chk_regs("R7");
    do_id(0);
    do_id(1);
    rw(2'd2, 16'h0B00);
    rw(2'd2, 16'h0A03);
    do_unk(16'h0091);
    bw(16'h00F0);
    m_blk = 0; m_page = 0; m_buf = 0; m_cnt = 1;
    chk_regs("R9");

    for (int n = 0; n < 300; n++) begin
      case ($urandom % 8)
        0: rw(2'd0, 16'($urandom));
        1: rw(2'd1, 16'($urandom));
        2: rw(2'd2, 16'($urandom));
        3: do_load(int'($urandom % 5), 1'($urandom % 2));
        4: do_id(1'($urandom % 2));
        5: begin bw(16'h00F0); m_blk = 0; m_page = 0; m_buf = 0; m_cnt = 1; chk_regs("R9"); end
        6: begin
          v = 16'($urandom);
          if (v == 16'h00F0 || v == 16'h00E0 || v == 16'h0090) v = 16'h0001;
          do_unk(v);
        end
        default: begin
          v = 16'($urandom) | 16'h0100;
          bw(16'h00E0); m_arm = 1; bw(v); m_arm = 0;
          chk(arr_req == 0 && unk_cmd == 0, "R7", arr_req, 0);
          chk_regs("R2");
        end
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule